// File: doc/BRIEF.md
# Two-Initiator Weighted Burst Arbiter

This block decides which of two initiators owns a shared external memory bus for the next access. One initiator is a direct interconnect port. The other is a prefetch and write-posting engine. Each initiator raises a level request. The arbiter replies with a one-cycle grant pulse for each access it awards. The bus side reports the end of an access with a single `acc_done` pulse. Only one access can be outstanding at a time.

Two schemes are available. In fixed-priority mode the direct port wins every contested decision. In weighted mode a contested bus alternates in turns: the direct port gets one access, then the engine keeps the bus for `eng_weight + 1` accesses in a row. The turn pattern restarts, with the direct port first, at any clock edge where the two requests are not both high. As a result, a direct request that arrives while the engine alone is using the bus takes the next grant. The engine then gets its full run, even though the direct port is still requesting.

The block moves no data, so it has no valid/ready stream. Requests, grants and `acc_done` are plain control pins. The bus never back-pressures a grant: it holds the slot until it pulses `acc_done`.

Top module: `wburst_arb`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), both grant outputs are low. The first contested grant in weighted mode goes to the direct port.
- R2: At most one access is outstanding. After a grant, no new grant appears until the cycle after the one in which `acc_done` is high. With an access latency of L cycles (done L cycles after the grant cycle), consecutive grants are L+1 cycles apart.
- R3: If the slot is free in a cycle (no access outstanding, or `acc_done` high) and a request is high, a grant pulse appears in the next cycle. A lone requester whose accesses finish in their grant cycle is granted on every cycle.
- R4: With `mode_weighted` = 0, the direct port wins every decision in which both initiators request.
- R5: With `mode_weighted` = 1 and both initiators requesting continuously, grants repeat as one direct grant followed by `eng_weight + 1` engine grants. With weight 2 this gives D,E,E,E,D,...
- R6: With weight 0, weighted mode strictly alternates direct and engine grants.
- R7: Any edge at which the two requests are not both high restarts the turn pattern. The next contested grant goes to the direct port, and the engine's full run follows it even if the direct port is still requesting.
- R8: `gnt_dir` and `gnt_eng` are never high in the same cycle. Each is a single-cycle pulse per awarded access.
- R9: `eng_weight` is an unsigned 4-bit field. Its maximum value, 15, gives a run of 16 engine grants per turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_weighted | input | 1 | 1 = weighted turns, 0 = fixed priority to the direct port |
| eng_weight | input | WEIGHT_W (4) | Extra engine accesses per turn |
| req_dir | input | 1 | Direct port request (level) |
| req_eng | input | 1 | Engine request (level) |
| acc_done | input | 1 | Pulse: the outstanding access has ended on the bus |
| gnt_dir | output | 1 | One-cycle grant pulse to the direct port |
| gnt_eng | output | 1 | One-cycle grant pulse to the engine |

## Verification
On every cycle, the bound checker enforces these rules:
- the two grants are mutually exclusive;
- no grant is issued while an access is outstanding;
- a free slot with a pending request is granted on the next cycle;
- the engine never wins against the direct port in fixed mode;
- no engine run exceeds the configured weight plus one.

The exact order of turns needs the bench's directed scenarios and its per-cycle reference model. These cover the D/E patterns for weights 0, 2 and 15, the late direct request while the engine is using the bus, and a one-cycle request drop in the middle of a run. The spacing of grants under a given access latency is also shown only by those scenarios.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_ENG  = 2'd2
  } src_e;
endpackage

// File: rtl/wbarb_slot.sv
// Tracks the single outstanding access on the shared bus.
module wbarb_slot (
  input  logic clk,
  input  logic rst,
  input  logic grant_now,
  input  logic acc_done,
  output logic slot_free
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)            busy_q <= 1'b0;
    else if (grant_now) busy_q <= 1'b1;
    else if (acc_done)  busy_q <= 1'b0;
  end

  // Slot is reusable in the cycle the access ends.
  assign slot_free = !busy_q || acc_done;
endmodule

// File: rtl/wbarb_turn.sv
// Turn state of the weighted scheme: whose turn it is and how far the engine run has gone.
module wbarb_turn
  import wbarb_pkg::*;
#(
  parameter int WEIGHT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_weighted,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic                both_req,
  input  src_e                pick,
  output logic                dir_turn
);
  logic                turn_q;
  logic [WEIGHT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !both_req || !mode_weighted) begin
      turn_q <= 1'b1;
      run_q  <= '0;
    end else begin
      unique case (pick)
        SRC_DIR: begin
          turn_q <= 1'b0;
          run_q  <= '0;
        end
        SRC_ENG: begin
          if (run_q >= weight) begin
            turn_q <= 1'b1;
            run_q  <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dir_turn = turn_q;
endmodule

// File: rtl/wbarb_pick.sv
// Combinational winner selection for the current cycle.
module wbarb_pick
  import wbarb_pkg::*;
(
  input  logic slot_free,
  input  logic req_dir,
  input  logic req_eng,
  input  logic mode_weighted,
  input  logic dir_turn,
  output src_e pick
);
  always_comb begin
    pick = SRC_NONE;
    if (slot_free) begin
      if (req_dir && req_eng)
        pick = (!mode_weighted || dir_turn) ? SRC_DIR : SRC_ENG;
      else if (req_dir)
        pick = SRC_DIR;
      else if (req_eng)
        pick = SRC_ENG;
    end
  end
endmodule

// File: rtl/wburst_arb.sv
module wburst_arb
  import wbarb_pkg::*;
#(
  parameter int WEIGHT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_weighted,
  input  logic [WEIGHT_W-1:0] eng_weight,
  input  logic                req_dir,
  input  logic                req_eng,
  input  logic                acc_done,
  output logic                gnt_dir,
  output logic                gnt_eng
);
  logic slot_free;
  logic dir_turn;
  logic both_req;
  logic grant_now;
  src_e pick;

  assign both_req  = req_dir && req_eng;
  assign grant_now = (pick != SRC_NONE);

  wbarb_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .grant_now (grant_now),
    .acc_done  (acc_done),
    .slot_free (slot_free)
  );

  wbarb_turn #(.WEIGHT_W(WEIGHT_W)) u_turn (
    .clk           (clk),
    .rst           (rst),
    .mode_weighted (mode_weighted),
    .weight        (eng_weight),
    .both_req      (both_req),
    .pick          (pick),
    .dir_turn      (dir_turn)
  );

  wbarb_pick u_pick (
    .slot_free     (slot_free),
    .req_dir       (req_dir),
    .req_eng       (req_eng),
    .mode_weighted (mode_weighted),
    .dir_turn      (dir_turn),
    .pick          (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_dir <= 1'b0;
      gnt_eng <= 1'b0;
    end else begin
      gnt_dir <= (pick == SRC_DIR);
      gnt_eng <= (pick == SRC_ENG);
    end
  end
endmodule

// File: rtl/wburst_arb_chk.sv
module wburst_arb_chk #(
  parameter int WEIGHT_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_weighted,
  input logic [WEIGHT_W-1:0] eng_weight,
  input logic                req_dir,
  input logic                req_eng,
  input logic                acc_done,
  input logic                gnt_dir,
  input logic                gnt_eng
);
  logic                gnt_any;
  logic                pend;
  logic [WEIGHT_W:0]   run;
  logic [WEIGHT_W-1:0] wq;

  assign gnt_any = gnt_dir || gnt_eng;

  // Access awarded in an earlier cycle and not yet finished.
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend || gnt_any) && !acc_done;
  end

  // Engine grants seen since the last direct grant of a contested stretch.
  always_ff @(posedge clk) begin
    wq <= eng_weight;
    if (rst || !(req_dir && req_eng) || !mode_weighted || (eng_weight != wq))
      run <= '0;
    else if (gnt_dir)
      run <= '0;
    else if (gnt_eng)
      run <= run + 1'b1;
  end

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(gnt_dir && gnt_eng));

  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_any |-> !pend);

  p_no_gap_r3: assert property (@(posedge clk) disable iff (rst)
    ((req_dir || req_eng) && (!(pend || gnt_any) || acc_done)) |=> gnt_any);

  p_fixed_dir_wins_r4: assert property (@(posedge clk) disable iff (rst)
    gnt_eng |-> !($past(req_dir) && !$past(mode_weighted)));

  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    gnt_eng |-> (run <= {1'b0, $past(eng_weight)}));
endmodule

bind wburst_arb wburst_arb_chk #(.WEIGHT_W(WEIGHT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_weighted (mode_weighted),
  .eng_weight    (eng_weight),
  .req_dir       (req_dir),
  .req_eng       (req_eng),
  .acc_done      (acc_done),
  .gnt_dir       (gnt_dir),
  .gnt_eng       (gnt_eng)
);

// File: tb/test_wburst_arb.sv
`timescale 1ns/1ps
module test_wburst_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_w = 1'b0;
  logic [3:0] wgt = 4'd0;
  logic       req_d = 1'b0;
  logic       req_e = 1'b0;
  logic       done = 1'b0;
  logic       gd, ge;

  always #2.5 clk = ~clk;

  wburst_arb i_wburst_arb (
    .clk(clk), .rst(rst), .mode_weighted(mode_w), .eng_weight(wgt),
    .req_dir(req_d), .req_eng(req_e), .acc_done(done),
    .gnt_dir(gd), .gnt_eng(ge)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  int    lat = 0;
  int    cyc = 0;
  byte   seq[$];
  int    gtimes[$];

  task automatic chk(input bit ok, input string t, input string act, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", t, act, exp);
    end
  endtask

  // Behavioural reference: the expected grant pulses for the next cycle.
  bit m_busy = 0, m_turn = 1, exp_d = 0, exp_e = 0;
  int m_cnt = 0;
  always @(posedge clk) begin
    bit both, free, pd, pe;
    cyc++;
    if (rst) begin
      m_busy = 0; m_turn = 1; m_cnt = 0; exp_d = 0; exp_e = 0;
    end else begin
      both = req_d && req_e;
      free = !m_busy || done;
      pd = 0; pe = 0;
      if (free) begin
        if (both) begin
          if (!mode_w || m_turn) pd = 1; else pe = 1;
        end else if (req_d) pd = 1;
        else if (req_e) pe = 1;
      end
      if (!both || !mode_w) begin
        m_turn = 1; m_cnt = 0;
      end else if (pd) begin
        m_turn = 0; m_cnt = 0;
      end else if (pe) begin
        if (m_cnt >= int'(wgt)) begin m_turn = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (pd || pe) m_busy = 1;
      else if (done) m_busy = 0;
      exp_d = pd; exp_e = pe;
    end
  end

  // Per-cycle comparison and grant recording.
  always @(negedge clk) begin
    chk((gd === exp_d) && (ge === exp_e), tag,
        $sformatf("d=%b e=%b", gd, ge), $sformatf("d=%b e=%b", exp_d, exp_e));
    chk(!(gd && ge), "R8", $sformatf("d=%b e=%b", gd, ge), "not both");
    if (gd) begin seq.push_back("D"); gtimes.push_back(cyc); end
    if (ge) begin seq.push_back("E"); gtimes.push_back(cyc); end
  end

  // Bus responder: done arrives lat cycles after the grant cycle.
  bit rsp_pend = 0;
  int rsp_wait = 0;
  always @(negedge clk) begin
    if (rst) begin
      done = 0; rsp_pend = 0;
    end else begin
      if (done) done = 0;
      if (gd || ge) begin rsp_pend = 1; rsp_wait = lat; end
      if (rsp_pend) begin
        if (rsp_wait == 0) begin done = 1; rsp_pend = 0; end
        else rsp_wait--;
      end
    end
  end

  function automatic string pat(int w, int n);
    string s = "";
    for (int i = 0; i < n; i++) s = $sformatf("%s%s", s, (i % (w + 2) == 0) ? "D" : "E");
    return s;
  endfunction

  function automatic string seq_str(int n);
    string s = "";
    for (int i = 0; i < n && i < seq.size(); i++) s = $sformatf("%s%c", s, seq[i]);
    return s;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_grants(int n);
    int guard = 0;
    while (seq.size() < n && guard < 2000) begin @(negedge clk); guard++; end
    #1;
  endtask

  task automatic run_both(input bit m, input int w, input int l, input int n,
                          input string exp, input string t);
    @(negedge clk);
    tag = t; mode_w = m; wgt = 4'(w); lat = l;
    seq.delete();
    req_d = 1; req_e = 1;
    wait_grants(n);
    req_d = 0; req_e = 0;
    chk(seq_str(n) == exp, t, seq_str(n), exp);
    idle(20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!gd && !ge, "R1", $sformatf("d=%b e=%b", gd, ge), "d=0 e=0");
    rst = 0;
    idle(2);
    chk(!gd && !ge, "R1", $sformatf("d=%b e=%b", gd, ge), "d=0 e=0 idle");

    // R1, R5: weight 2 pattern, first grant direct
    run_both(1, 2, 1, 12, pat(2, 12), "R5");
    // R6: weight 0 alternates
    run_both(1, 0, 0, 10, pat(0, 10), "R6");
    // R9: maximum weight gives 16 engine grants
    run_both(1, 15, 0, 20, pat(15, 20), "R9");
    // R4: fixed priority, direct always
    run_both(0, 5, 0, 8, "DDDDDDDD", "R4");

    // R3: lone engine, done in grant cycle, granted every cycle
    @(negedge clk);
    tag = "R3"; mode_w = 1; wgt = 4'd2; lat = 0;
    seq.delete();
    req_e = 1;
    repeat (20) @(negedge clk);
    #1;
    chk(seq.size() == 20, "R3", $sformatf("%0d", seq.size()), "20");
    req_e = 0;
    idle(10);

    // R2: lone direct with latency 4, grants 5 cycles apart
    @(negedge clk);
    tag = "R2"; lat = 4;
    seq.delete(); gtimes.delete();
    req_d = 1;
    wait_grants(3);
    req_d = 0;
    chk(gtimes[1] - gtimes[0] == 5, "R2", $sformatf("%0d", gtimes[1] - gtimes[0]), "5");
    chk(gtimes[2] - gtimes[1] == 5, "R2", $sformatf("%0d", gtimes[2] - gtimes[1]), "5");
    idle(15);

    // R7: direct request arriving during an engine-only stretch
    @(negedge clk);
    tag = "R7"; mode_w = 1; wgt = 4'd2; lat = 2;
    req_e = 1;
    idle(10);
    req_d = 1;
    #1;
    seq.delete();
    wait_grants(5);
    req_d = 0; req_e = 0;
    chk(seq_str(5) == "DEEED", "R7", seq_str(5), "DEEED");
    idle(15);

    // R7: one-cycle drop of the direct request mid-run restarts the pattern
    @(negedge clk);
    tag = "R7"; wgt = 4'd3; lat = 0;
    seq.delete();
    req_d = 1; req_e = 1;
    wait_grants(3);
    chk(seq_str(3) == "DEE", "R7", seq_str(3), "DEE");
    @(negedge clk);
    req_d = 0;
    @(negedge clk);
    req_d = 1;
    #1;
    seq.delete();
    wait_grants(6);
    req_d = 0; req_e = 0;
    chk(seq_str(6) == "DEEEED", "R7", seq_str(6), "DEEEED");
    idle(10);

    // R1: synchronous reset mid-traffic clears grants and restarts with direct
    @(negedge clk);
    tag = "R1"; wgt = 4'd1; lat = 0;
    req_d = 1; req_e = 1;
    idle(3);
    rst = 1;
    idle(2);
    chk(!gd && !ge, "R1", $sformatf("d=%b e=%b", gd, ge), "d=0 e=0");
    rst = 0;
    #1;
    seq.delete();
    wait_grants(4);
    req_d = 0; req_e = 0;
    chk(seq_str(4) == "DEED", "R1", seq_str(4), "DEED");
    idle(5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule